// File: doc/BRIEF.md
# I2C Serial EEPROM Slave

This block is the slave side of a two-wire serial memory. It watches an SCL input and an open-drain SDA line, both sampled with the system clock. It finds START, repeated START and STOP conditions on the bus. It answers a device select whose upper nibble is 1010 and takes the read/write direction from bit 0. It holds the stored bytes in an internal register array, which is set to all ones on reset.

One address counter serves both paths. On a write it is loaded from the word address. On a read it steps after every byte it sends. Writes may be single bytes or pages of up to eight bytes. Reads may start from the current counter, from a random address set by a dummy write, or run on sequentially while the master keeps acknowledging.

A STOP that ends a write with stored data starts an internal write cycle of a fixed number of clocks. During that cycle the device select gets no acknowledge, so a master can poll until it is acknowledged. A write-enable input, when low, stops any byte from reaching the memory.

Top module: `i2c_ee_slave`

## Requirements
- R1: After reset every location reads as FFh, and SDA is not driven.
- R2: A device select is acknowledged only when its bits 7:4 equal 1010. Bits 3:1 are don't-care, and bit 0 is RW (1 = read, 0 = write).
- R3: A write of device select (RW=0), word address and one data byte stores the byte at that address.
- R4: A current address read (device select with RW=1 straight after START) returns the byte at the counter. The counter then steps by one for each byte sent.
- R5: A dummy write of the word address, then a repeated START and a device select with RW=1, returns the byte at that word address.
- R6: A sequential read goes on while the master drives the 9th bit low. After address 127 the counter wraps to 0 with no gap in the data.
- R7: When the master leaves SDA high in the 9th bit of a read byte, the slave releases SDA and drives nothing on further clocks until the next START.
- R8: After a STOP that ends a write with at least one stored byte, the device select gets no acknowledge for WRITE_CYCLES clocks. After that it is acknowledged again.
- R9: Each data byte of a page write is acknowledged and stored, for up to 8 bytes. The address wraps inside its 8-byte page: bits 6:3 stay fixed and bits 2:0 count modulo 8.
- R10: While the write-enable input is 0, data bytes get no acknowledge, memory is unchanged and no internal write cycle starts. Device select and word address are still acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that samples the bus |
| rst_i | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock from the master |
| sda_i | input | 1 | Sensed level of the SDA line |
| wr_en_i | input | 1 | Write enable: 1 allows writes, 0 blocks them |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain) |

## Verification
The bench builds the block with the default 7-bit address and 8-byte page. It shortens WRITE_CYCLES to 300 clocks, so one poll can land inside the busy window and a later poll outside it. With 128 locations, a sequential read across address 127 reaches the counter wrap in a short run. The page write starts in the middle of a page, which exercises the wrap of the low three address bits back to the start of the page.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_ADDR,
        ST_WDATA,
        ST_RDATA
    } ee_state_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_evt_t;

    function automatic logic devsel_hit(input logic [BYTE_W-1:0] b,
                                        input logic [3:0] code);
        return b[7:4] == code;
    endfunction

    function automatic logic [BYTE_W-1:0] shift_in(input logic [BYTE_W-1:0] s,
                                                   input logic bit_in);
        return {s[BYTE_W-2:0], bit_in};
    endfunction

endpackage

// File: rtl/i2c_ee_bus_sense.sv
module i2c_ee_bus_sense
    import i2c_ee_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_i,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt_o
);
    logic [2:0] scl_sh;
    logic [2:0] sda_sh;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            scl_sh <= 3'b111;
            sda_sh <= 3'b111;
        end else begin
            scl_sh <= {scl_sh[1:0], scl_i};
            sda_sh <= {sda_sh[1:0], sda_i};
        end
    end

    always_comb begin
        evt_o.scl_rise = scl_sh[1] & ~scl_sh[2];
        evt_o.scl_fall = ~scl_sh[1] & scl_sh[2];
        evt_o.start    = scl_sh[1] & scl_sh[2] & sda_sh[2] & ~sda_sh[1];
        evt_o.stop     = scl_sh[1] & scl_sh[2] & ~sda_sh[2] & sda_sh[1];
        evt_o.sda      = sda_sh[1];
    end
endmodule

// File: rtl/i2c_ee_store.sv
module i2c_ee_store #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (we_i) begin
            mem[waddr_i] <= wdata_i;
        end
    end

    assign rd_data_o = mem[raddr_i];

    // R1: first read after reset returns all ones
    a_r1_fill: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> rd_data_o == '1);
endmodule

// File: rtl/i2c_ee_wtimer.sv
module i2c_ee_wtimer #(
    parameter int CYCLES = 1000000
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic start_i,
    output logic busy_o
);
    localparam int CNT_W = $clog2(CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CYCLES);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)                cnt_q <= '0;
        else if (start_i)         cnt_q <= CNT_LOAD;
        else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
    end

    assign busy_o = cnt_q != '0;

    // R8: a started write cycle makes the block busy
    a_r8_busy_start: assert property (@(posedge clk_i) disable iff (rst_i)
        start_i |=> busy_o);
endmodule

// File: rtl/i2c_ee_slave.sv
module i2c_ee_slave
    import i2c_ee_pkg::*;
#(
    parameter int         ADDR_W       = 7,
    parameter int         PAGE_BYTES   = 8,
    parameter int         WRITE_CYCLES = 1000000,
    parameter logic [3:0] DEV_CODE     = 4'b1010
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wr_en_i,
    output logic sda_oe_o
);
    localparam int PG_W = $clog2(PAGE_BYTES);
    localparam logic [PG_W-1:0]   PG_ONE   = 1;
    localparam logic [ADDR_W-1:0] ADDR_ONE = 1;

    bus_evt_t          evt;
    ee_state_e         state_q;
    logic [3:0]        bitcnt_q;
    logic [BYTE_W-1:0] shreg_q;
    logic [BYTE_W-1:0] txbyte_q;
    logic [BYTE_W-1:0] rx_byte;
    logic [ADDR_W-1:0] addr_q;
    logic [BYTE_W-1:0] rd_data;
    logic              ack_q;
    logic              rw_q;
    logic              dirty_q;
    logic              sda_oe_q;
    logic              busy;
    logic              mem_we;
    logic              wcyc_start;
    logic              byte_edge;
    logic              ack_edge;

    i2c_ee_bus_sense u_sense (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt_o (evt)
    );

    i2c_ee_store #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_store (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .we_i      (mem_we),
        .waddr_i   (addr_q),
        .wdata_i   (rx_byte),
        .raddr_i   (addr_q),
        .rd_data_o (rd_data)
    );

    i2c_ee_wtimer #(.CYCLES(WRITE_CYCLES)) u_wtimer (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .start_i (wcyc_start),
        .busy_o  (busy)
    );

    assign rx_byte    = shift_in(shreg_q, evt.sda);
    assign byte_edge  = evt.scl_rise && (bitcnt_q == 4'd7);
    assign ack_edge   = evt.scl_rise && (bitcnt_q == 4'd8);
    assign mem_we     = byte_edge && (state_q == ST_WDATA) && wr_en_i
                        && !evt.start && !evt.stop;
    assign wcyc_start = evt.stop && dirty_q;
    assign sda_oe_o   = sda_oe_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q  <= ST_IDLE;
            bitcnt_q <= '0;
            shreg_q  <= '0;
            txbyte_q <= '1;
            addr_q   <= '0;
            ack_q    <= 1'b0;
            rw_q     <= 1'b0;
            dirty_q  <= 1'b0;
            sda_oe_q <= 1'b0;
        end else if (evt.start) begin
            state_q  <= ST_DEV;
            bitcnt_q <= '0;
            sda_oe_q <= 1'b0;
        end else if (evt.stop) begin
            state_q  <= ST_IDLE;
            bitcnt_q <= '0;
            sda_oe_q <= 1'b0;
            dirty_q  <= 1'b0;
        end else if (state_q != ST_IDLE) begin
            if (evt.scl_rise) begin
                if (bitcnt_q != 4'd8) begin
                    bitcnt_q <= bitcnt_q + 4'd1;
                    shreg_q  <= rx_byte;
                end
                if (byte_edge) begin
                    unique case (state_q)
                        ST_DEV: begin
                            ack_q <= devsel_hit(rx_byte, DEV_CODE) && !busy;
                            rw_q  <= rx_byte[0];
                        end
                        ST_ADDR: begin
                            ack_q  <= 1'b1;
                            addr_q <= rx_byte[ADDR_W-1:0];
                        end
                        ST_WDATA: begin
                            ack_q <= wr_en_i;
                            if (wr_en_i) begin
                                dirty_q <= 1'b1;
                                addr_q  <= {addr_q[ADDR_W-1:PG_W],
                                            addr_q[PG_W-1:0] + PG_ONE};
                            end
                        end
                        default: ack_q <= 1'b0;
                    endcase
                end
                if (ack_edge) begin
                    bitcnt_q <= '0;
                    unique case (state_q)
                        ST_DEV: begin
                            if (!ack_q)    state_q <= ST_IDLE;
                            else if (rw_q) begin
                                state_q  <= ST_RDATA;
                                txbyte_q <= rd_data;
                                addr_q   <= addr_q + ADDR_ONE;
                            end else       state_q <= ST_ADDR;
                        end
                        ST_ADDR:  state_q <= ST_WDATA;
                        ST_WDATA: if (!ack_q) state_q <= ST_IDLE;
                        ST_RDATA: begin
                            if (evt.sda) state_q <= ST_IDLE;
                            else begin
                                txbyte_q <= rd_data;
                                addr_q   <= addr_q + ADDR_ONE;
                            end
                        end
                        default:  state_q <= ST_IDLE;
                    endcase
                end
            end else if (evt.scl_fall) begin
                if (state_q == ST_RDATA && bitcnt_q != 4'd8)
                    sda_oe_q <= ~txbyte_q[3'd7 - bitcnt_q[2:0]];
                else if (state_q != ST_RDATA && bitcnt_q == 4'd8)
                    sda_oe_q <= ack_q;
                else
                    sda_oe_q <= 1'b0;
            end
        end
    end

    // R7: the line is left alone whenever the slave is in standby
    a_r7_idle_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_IDLE) |-> !sda_oe_q);

    // R8: no acknowledge for the device select while the write cycle runs
    a_r8_busy_nack: assert property (@(posedge clk_i) disable iff (rst_i)
        (evt.scl_fall && state_q == ST_DEV && bitcnt_q == 4'd8 && busy)
        |=> !sda_oe_q);

    // R9: page writes keep the page bits of the counter fixed
    a_r9_page_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        mem_we |=> addr_q[ADDR_W-1:PG_W] == $past(addr_q[ADDR_W-1:PG_W]));

    // R10: data bytes are not acknowledged while writes are blocked
    a_r10_inhibit_nack: assert property (@(posedge clk_i) disable iff (rst_i)
        (evt.scl_fall && state_q == ST_WDATA && bitcnt_q == 4'd8 && !wr_en_i
         && !ack_q) |=> !sda_oe_q);

    // R4: a byte acknowledged by the master advances the counter by one
    a_r4_step: assert property (@(posedge clk_i) disable iff (rst_i)
        (ack_edge && state_q == ST_RDATA && !evt.sda && !evt.start && !evt.stop)
        |=> addr_q == $past(addr_q) + ADDR_ONE);
endmodule

// File: tb/i2c_ee_slave_test.sv
module i2c_ee_slave_test;
    localparam int Q      = 8;
    localparam int WR_CYC = 300;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic m_low = 1'b0;
    logic wr_en = 1'b1;
    logic sda_oe;
    logic sda_line;
    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_line = !(m_low || sda_oe);

    i2c_ee_slave #(.WRITE_CYCLES(WR_CYC)) uut (
        .clk_i    (clk),
        .rst_i    (rst),
        .scl_i    (scl),
        .sda_i    (sda_line),
        .wr_en_i  (wr_en),
        .sda_oe_o (sda_oe)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic i2c_start;
        m_low = 1'b0; tick(Q);
        scl = 1'b1;   tick(Q);
        m_low = 1'b1; tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic i2c_stop;
        m_low = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        m_low = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_low = !b[i]; tick(Q);
            scl = 1'b1;    tick(Q);
            scl = 1'b0;
        end
        m_low = 1'b0; tick(Q);
        scl = 1'b1;   tick(Q / 2);
        ack = !sda_line;
        tick(Q / 2);
        scl = 1'b0;
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic m_ack);
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl = 1'b1; tick(Q / 2);
            b[i] = sda_line;
            tick(Q / 2);
            scl = 1'b0;
        end
        m_low = m_ack; tick(Q);
        scl = 1'b1;    tick(Q);
        scl = 1'b0;    tick(1);
        m_low = 1'b0;
    endtask

    task automatic poll(output logic ack);
        i2c_start;
        send_byte(8'hA0, ack);
        i2c_stop;
    endtask

    task automatic wait_ready;
        logic a;
        for (int k = 0; k < 20; k++) begin
            poll(a);
            if (a) break;
            tick(100);
        end
    endtask

    task automatic set_addr_read(input logic [7:0] addr, input string req);
        logic a;
        i2c_start;
        send_byte(8'hA0, a);   check({req, " dummy write select ack"}, a, 1);
        send_byte(addr, a);    check({req, " dummy address ack"}, a, 1);
        i2c_start;
        send_byte(8'hA1, a);   check({req, " read select ack"}, a, 1);
    endtask

    task automatic byte_write(input logic [7:0] addr, input logic [7:0] d);
        logic a0, a1, a2;
        i2c_start;
        send_byte(8'hA0, a0);
        send_byte(addr, a1);
        send_byte(d, a2);
        i2c_stop;
        check("R3 byte write acks", {a0, a1, a2}, 3'b111);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        check("R1 SDA released after reset", sda_line, 1);
        set_addr_read(8'h10, "R5");
        recv_byte(d, 1'b0);
        i2c_stop;
        check("R1 reset content FFh at 0x10", d, 8'hFF);
    endtask

    task automatic t_devsel;
        logic a;
        i2c_start;
        send_byte(8'h50, a);
        i2c_stop;
        check("R2 wrong code 0101 not acked", a, 0);
        i2c_start;
        send_byte(8'hAE, a);
        i2c_stop;
        check("R2 code 1010 with don't-care bits acked", a, 1);
    endtask

    task automatic t_byte_write;
        logic a;
        logic [7:0] d;
        byte_write(8'h08, 8'h5A);
        poll(a);
        check("R8 poll during write cycle not acked", a, 0);
        tick(WR_CYC);
        poll(a);
        check("R8 poll after write cycle acked", a, 1);
        set_addr_read(8'h08, "R5");
        recv_byte(d, 1'b0);
        i2c_stop;
        check("R3 stored byte read back at 0x08", d, 8'h5A);
    endtask

    task automatic t_page;
        logic a;
        logic [7:0] d;
        logic [7:0] exp;
        int nacks = 0;
        i2c_start;
        send_byte(8'hA0, a); check("R9 page select ack", a, 1);
        send_byte(8'h04, a); check("R9 page address ack", a, 1);
        for (int i = 0; i < 8; i++) begin
            send_byte(8'h10 + 8'(i), a);
            if (!a) nacks++;
        end
        i2c_stop;
        check("R9 all eight data bytes acked", nacks, 0);
        wait_ready;
        set_addr_read(8'h00, "R5");
        for (int i = 0; i < 8; i++) begin
            recv_byte(d, i != 7);
            exp = (i < 4) ? 8'h14 + 8'(i) : 8'h10 + 8'(i - 4);
            check($sformatf("R9 page wrap byte at %0d", i), d, exp);
        end
        i2c_stop;
        i2c_start;
        send_byte(8'hA1, a);
        recv_byte(d, 1'b0);
        i2c_stop;
        check("R4 current address read at 0x08", d, 8'h5A);
        i2c_start;
        send_byte(8'hA1, a);
        recv_byte(d, 1'b0);
        i2c_stop;
        check("R4 counter stepped to 0x09", d, 8'hFF);
    endtask

    task automatic t_wrap;
        logic [7:0] d;
        byte_write(8'h7F, 8'hC3);
        wait_ready;
        set_addr_read(8'h7F, "R6");
        recv_byte(d, 1'b1);
        check("R6 byte at 0x7F", d, 8'hC3);
        recv_byte(d, 1'b0);
        i2c_stop;
        check("R6 wrap to 0x00", d, 8'h14);
    endtask

    task automatic t_nack;
        logic [7:0] d;
        int driven = 0;
        set_addr_read(8'h05, "R5");
        recv_byte(d, 1'b0);
        check("R5 random read at 0x05", d, 8'h11);
        for (int i = 0; i < 9; i++) begin
            tick(Q);
            scl = 1'b1; tick(Q / 2);
            if (!sda_line) driven++;
            tick(Q / 2);
            scl = 1'b0;
        end
        i2c_stop;
        check("R7 no drive after master NACK", driven, 0);
    endtask

    task automatic t_inhibit;
        logic a0, a1, a2, a;
        logic [7:0] d;
        wr_en = 1'b0;
        tick(4);
        i2c_start;
        send_byte(8'hA0, a0);
        send_byte(8'h08, a1);
        send_byte(8'h00, a2);
        i2c_stop;
        check("R10 select and address acked", {a0, a1}, 2'b11);
        check("R10 data byte not acked", a2, 0);
        poll(a);
        check("R10 no write cycle started", a, 1);
        set_addr_read(8'h08, "R10");
        recv_byte(d, 1'b0);
        i2c_stop;
        check("R10 memory unchanged at 0x08", d, 8'h5A);
        wr_en = 1'b1;
    endtask

    initial begin
        tick(10);
        rst = 1'b0;
        tick(10);
        t_reset;
        t_devsel;
        t_byte_write;
        t_page;
        t_wrap;
        t_nack;
        t_inhibit;
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule